// File: doc/BRIEF.md
# Phase-Frequency Detector with Loop Sense, Gain Select and Lock Indication

This block compares a divided reference pulse train with a divided RF pulse train. It drives the UP and DOWN controls of a charge pump from a two-flag detector, so there is no dead band. A loop-sense input swaps which comparison input leads to UP and which leads to DOWN, so that loop filters of either polarity can be used. While the strobe is high, the pump drive is held off. During that time a two-bit gain code passes through to the gain select output, and the code is held once the strobe falls.

All logic runs on one sample clock. The divided inputs are sampled on that clock, and a rising edge is detected when a sample is high and the previous one was low. A digital counter takes the place of an analog lock integrator. It counts reference periods in which no wide correction pulse appears, and it asserts the lock output once enough of those periods have occurred in a row. Two monitor outputs carry the divided reference and the divided RF signal, and they trade places when the loop sense is reversed.

Top module: `pfd_lock`

## Requirements
- R1: With `loop_sense` high, a reference rising edge that comes d sample cycles before the RF rising edge gives `pump_up` high for d+1 cycles and `pump_dn` high for 1 cycle. An RF edge leading by d cycles gives the mirror image: `pump_dn` for d+1 cycles and `pump_up` for 1 cycle.
- R2: Rising edges that arrive in the same cycle give `pump_up` and `pump_dn` high together for exactly one cycle. A one-cycle phase error still gives a pulse that is one cycle longer on the leading side.
- R3: With `loop_sense` low, the roles of `pump_up` and `pump_dn` are exchanged.
- R4: When the RF input runs faster than the reference, `loop_sense` high gives more `pump_dn` cycles than `pump_up` cycles over a window.
- R5: While `strobe` is high, `pump_up` and `pump_dn` are both low, and any pending comparison is discarded.
- R6: While `strobe` is high, `gain_sel` follows `gain_code`. While `strobe` is low, `gain_sel` holds the last code seen with the strobe high. Codes 0, 1, 2 and 3 select pump gains of x1, x1.5, x2.5 and x4.
- R7: `lock` rises on the LOCK_PERIODS-th consecutive reference rising edge that has no wide pulse since the strobe fell or since the last wide pulse. A wide pulse is one in which `pump_up` or `pump_dn` stays high for more than WIDE_CYC cycles.
- R8: A wide pulse clears `lock` on the next clock. Raising `strobe` also clears `lock` and the period count.
- R9: With `loop_sense` high, `fref_mon` equals `ref_div` and `fpd_mon` equals `rf_div`. With `loop_sense` low, the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference pulse train |
| rf_div | input | 1 | Divided RF pulse train |
| loop_sense | input | 1 | Loop sense; high gives normal polarity |
| strobe | input | 1 | Load strobe; high disables the pump and opens the gain code |
| gain_code | input | 2 | Pump gain code |
| pump_up | output | 1 | Charge pump source control |
| pump_dn | output | 1 | Charge pump sink control |
| gain_sel | output | 2 | Held pump gain select |
| lock | output | 1 | Phase lock indication |
| fref_mon | output | 1 | Monitor output, reference side |
| fpd_mon | output | 1 | Monitor output, RF side |

## Verification
The detector is driven with several input patterns:
- Aligned edges show the one-cycle minimum pulse on both outputs.
- A reference lead and an RF lead of three cycles, each with both settings of the loop sense, separate the polarity cases from one another.
- A one-cycle lead shows that there is no dead band.
- An RF train at twice the reference rate shows the frequency-detecting behaviour, as opposed to phase-only comparison.

For lock, a series of aligned periods is followed by one wide lead, so that both the count to lock and the immediate loss of lock are observed.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_PERIODS = 4,
  parameter int WIDE_CYC     = 2,
  localparam int GW = $clog2(LOCK_PERIODS + 1),
  localparam int WW = $clog2(WIDE_CYC + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_div,
  input  logic       rf_div,
  input  logic       loop_sense,
  input  logic       strobe,
  input  logic [1:0] gain_code,
  output logic       pump_up,
  output logic       pump_dn,
  output logic [1:0] gain_sel,
  output logic       lock,
  output logic       fref_mon,
  output logic       fpd_mon
);

  logic ref_q, rf_q, flag_r, flag_v, bad;
  logic [1:0] gain_q;
  logic [GW-1:0] good;
  logic [WW-1:0] wcnt;

  wire ref_rise = ref_div & ~ref_q;
  wire rf_rise  = rf_div & ~rf_q;
  wire active   = flag_r | flag_v;
  wire wide     = active && (int'(wcnt) >= WIDE_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      rf_q  <= 1'b0;
    end else begin
      ref_q <= ref_div;
      rf_q  <= rf_div;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe) begin
      flag_r <= 1'b0;
      flag_v <= 1'b0;
    end else if (flag_r && flag_v) begin
      flag_r <= ref_rise;
      flag_v <= rf_rise;
    end else begin
      flag_r <= flag_r | ref_rise;
      flag_v <= flag_v | rf_rise;
    end
  end

  assign pump_up  = ~strobe & (loop_sense ? flag_r : flag_v);
  assign pump_dn  = ~strobe & (loop_sense ? flag_v : flag_r);
  assign fref_mon = loop_sense ? ref_div : rf_div;
  assign fpd_mon  = loop_sense ? rf_div : ref_div;

  always_ff @(posedge clk) begin
    if (!rst_n)      gain_q <= 2'd0;
    else if (strobe) gain_q <= gain_code;
  end
  assign gain_sel = strobe ? gain_code : gain_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) wcnt <= '0;
    else if (!wide)        wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe) begin
      lock <= 1'b0;
      good <= '0;
      bad  <= 1'b0;
    end else if (wide) begin
      lock <= 1'b0;
      good <= '0;
      bad  <= 1'b1;
    end else if (ref_rise) begin
      if (bad) begin
        bad  <= 1'b0;
        good <= '0;
      end else begin
        if (int'(good) < LOCK_PERIODS) good <= good + 1'b1;
        if (int'(good) + 1 >= LOCK_PERIODS) lock <= 1'b1;
      end
    end
  end

  // R5
  strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !(flag_r || flag_v));

  // R2
  min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |=> !(pump_up && pump_dn));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe)) |-> $stable(gain_sel));

  // R8
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lock);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ref_rise));

endmodule

// File: tb/pfd_lock_test.sv
module pfd_lock_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_div = 1'b0, rf_div = 1'b0, loop_sense = 1'b1, strobe = 1'b0;
  logic [1:0] gain_code = 2'd0;
  logic pump_up, pump_dn, lock, fref_mon, fpd_mon;
  logic [1:0] gain_sel;
  int checks = 0, errors = 0;
  int nup, ndn;

  always #2.5 clk = ~clk;

  pfd_lock uut (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .rf_div(rf_div),
    .loop_sense(loop_sense), .strobe(strobe), .gain_code(gain_code),
    .pump_up(pump_up), .pump_dn(pump_dn), .gain_sel(gain_sel), .lock(lock),
    .fref_mon(fref_mon), .fpd_mon(fpd_mon)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_strobe();
    @(negedge clk); strobe = 1'b1; ref_div = 1'b0; rf_div = 1'b0;
    @(negedge clk); @(negedge clk); strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic period(input int ra, input int va, input int per);
    nup = 0; ndn = 0;
    for (int c = 0; c < per; c++) begin
      @(negedge clk);
      nup += int'(pump_up); ndn += int'(pump_dn);
      ref_div = (c >= ra && c < ra + 3);
      rf_div  = (c >= va && c < va + 3);
    end
  endtask

  task automatic t_reset();
    check("R1 reset up", int'(pump_up), 0);
    check("R1 reset dn", int'(pump_dn), 0);
    check("R7 reset lock", int'(lock), 0);
  endtask

  task automatic t_phase();
    loop_sense = 1'b1; clear_strobe();
    period(2, 2, 16);
    check("R2 aligned up", nup, 1); check("R2 aligned dn", ndn, 1);
    period(2, 5, 16);
    check("R1 ref lead up", nup, 4); check("R1 ref lead dn", ndn, 1);
    period(5, 2, 16);
    check("R1 rf lead dn", ndn, 4); check("R1 rf lead up", nup, 1);
    period(2, 3, 16);
    check("R2 one-cycle up", nup, 2); check("R2 one-cycle dn", ndn, 1);
  endtask

  task automatic t_sense();
    loop_sense = 1'b0; clear_strobe();
    period(2, 5, 16);
    check("R3 ref lead dn", ndn, 4); check("R3 ref lead up", nup, 1);
    period(5, 2, 16);
    check("R3 rf lead up", nup, 4); check("R3 rf lead dn", ndn, 1);
    loop_sense = 1'b1;
  endtask

  task automatic t_freq();
    int u = 0, d = 0;
    loop_sense = 1'b1; clear_strobe();
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      u += int'(pump_up); d += int'(pump_dn);
      ref_div = ((c % 16) >= 4 && (c % 16) < 7);
      rf_div  = ((c % 8) < 2);
    end
    check("R4 dn exceeds up", int'(d > u), 1);
  endtask

  task automatic t_strobe();
    @(negedge clk); strobe = 1'b1;
    nup = 0; ndn = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      nup += int'(pump_up); ndn += int'(pump_dn);
      ref_div = (c >= 2 && c < 5);
      rf_div  = (c >= 8 && c < 11);
    end
    check("R5 strobe up", nup, 0); check("R5 strobe dn", ndn, 0);
    @(negedge clk); strobe = 1'b0; ref_div = 1'b0; rf_div = 1'b0;
  endtask

  task automatic t_gain();
    @(negedge clk); strobe = 1'b1; gain_code = 2'd2;
    #1 check("R6 transparent", int'(gain_sel), 2);
    @(negedge clk); gain_code = 2'd1;
    #1 check("R6 transparent 2", int'(gain_sel), 1);
    @(negedge clk); strobe = 1'b0; gain_code = 2'd3;
    @(negedge clk); @(negedge clk);
    check("R6 held", int'(gain_sel), 1);
  endtask

  task automatic t_lock();
    loop_sense = 1'b1; clear_strobe();
    for (int p = 1; p <= 4; p++) begin
      period(2, 2, 16);
      check("R7 lock count", int'(lock), p >= 4 ? 1 : 0);
    end
    period(2, 6, 16);
    check("R8 wide clears lock", int'(lock), 0);
    for (int p = 0; p < 5; p++) period(2, 2, 16);
    check("R7 relock", int'(lock), 1);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk);
    check("R8 strobe clears lock", int'(lock), 0);
    strobe = 1'b0;
  endtask

  task automatic t_mon();
    @(negedge clk); ref_div = 1'b1; rf_div = 1'b0; loop_sense = 1'b1;
    #1 check("R9 fref normal", int'(fref_mon), 1);
    check("R9 fpd normal", int'(fpd_mon), 0);
    loop_sense = 1'b0;
    #1 check("R9 fref swapped", int'(fref_mon), 0);
    check("R9 fpd swapped", int'(fpd_mon), 1);
    @(negedge clk); ref_div = 1'b0; loop_sense = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(); t_phase(); t_sense(); t_freq(); t_strobe();
        t_gain(); t_lock(); t_mon();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule